// File: doc/BRIEF.md
# Keyed Control-Register Guard

This block holds one protected control register behind a two-step key sequence. Software writes bytes to a dedicated key register. Only the ordered pair of key values opens write access to the control register. While access is closed, writes to the control register are dropped. Any key-register write that is not one of the two key values closes access again.

Bit 0 of the control register asks for a programming mode. The request does not act at once. The block samples that bit only when an idle-wake pulse arrives, and drives a registered mode-entry level from it. A status register reports whether access is open. The key register itself always reads as zero.

The register bus is a plain one: address, write strobe, write data and combinational read data. Register map: key register at address 0, control register at address 1, status register at address 2 (bit 0 = 1 when access is open). Every other address reads as zero.

Top module: `key_guard_top`

## Requirements
- R1: After reset, the control register reads 00h, the status register reads 00h (closed), and modeReq is 0.
- R2: A write to the control register (address 1) while access is closed leaves its contents unchanged.
- R3: Writing 87h and then 59h to the key register (address 0) opens access. After that, status bit 0 reads 1 and control-register writes take effect on the next clock.
- R4: Only key-register writes count toward the sequence. A 59h that is not directly preceded by 87h leaves access closed. A repeated 87h restarts the sequence, so 87h, 87h, 59h opens access.
- R5: Writing any value other than 87h or 59h to the key register closes access, whether the sequence is open or half complete.
- R6: Once open, access stays open across any number of control-register writes, and across further writes of 87h or 59h to the key register.
- R7: The key register reads as 00h at all times.
- R8: modeReq changes only on a clock where idleWake is high. On such a clock it takes the value that bit 0 of the control register held before that edge. Setting or clearing bit 0 alone does not move modeReq.
- R9: When a control-register write and an idle-wake fall on the same clock, modeReq takes the bit 0 value from before the write, and the write still lands in the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register address |
| busWe | input | 1 | Write strobe, one write per high clock |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| idleWake | input | 1 | One-cycle pulse marking wake-up from idle |
| modeReq | output | 1 | Registered programming-mode entry level |

## Verification
The bench uses the default parameters: 8-bit data, a 4-bit address, keys 87h and 59h, register addresses 0, 1 and 2, and mode bit 0. With these values the bench drives the exact key values, a lone second key, a broken pair and a repeated first key. It also drives unused data values that must relock access. Each case is observed through the status and control read-back. The one-bit mode field lets the bench line up a control write and an idle-wake on the same clock, which shows that the wake samples the old value.

// File: rtl/key_guard_pkg.sv
package key_guard_pkg;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic keyWr;
    logic ctrlLoad;
    logic unlocked;
  } guard_strobe_t;

endpackage

// File: rtl/key_guard_ctrl.sv
module key_guard_ctrl
  import key_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned KEY_ADDR   = 0,
  parameter int unsigned CTRL_ADDR  = 1,
  parameter int unsigned KEY_FIRST  = 'h87,
  parameter int unsigned KEY_SECOND = 'h59
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output guard_strobe_t     strobes
);

  localparam logic [ADDR_W-1:0] KeyA  = ADDR_W'(KEY_ADDR);
  localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);
  localparam logic [DATA_W-1:0] Key1  = DATA_W'(KEY_FIRST);
  localparam logic [DATA_W-1:0] Key2  = DATA_W'(KEY_SECOND);

  lock_state_e lockState, lockNext;
  logic        isKeyWr;
  logic        isCtrlWr;
  logic        isKey1;
  logic        isKey2;

  always_comb begin
    isKeyWr  = busWe && (busAddr == KeyA);
    isCtrlWr = busWe && (busAddr == CtrlA);
    isKey1   = (busWdata == Key1);
    isKey2   = (busWdata == Key2);
  end

  // Sequence tracking: only key-register writes move the state
  always_comb begin
    lockNext = lockState;
    if (isKeyWr) begin
      unique case (lockState)
        LK_CLOSED: lockNext = isKey1 ? LK_ARMED : LK_CLOSED;
        LK_ARMED: begin
          if (isKey2)      lockNext = LK_OPEN;
          else if (isKey1) lockNext = LK_ARMED;
          else             lockNext = LK_CLOSED;
        end
        LK_OPEN:   lockNext = (isKey1 || isKey2) ? LK_OPEN : LK_CLOSED;
        default:   lockNext = LK_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockState <= LK_CLOSED;
    else       lockState <= lockNext;
  end

  always_comb begin
    strobes.keyWr    = isKeyWr;
    strobes.unlocked = (lockState == LK_OPEN);
    strobes.ctrlLoad = isCtrlWr && (lockState == LK_OPEN);
  end

  AST_OPEN_NEEDS_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.unlocked) |-> $past(busWe && busAddr == KeyA && busWdata == Key2)); // R3

  AST_BAD_KEY_RELOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == KeyA && busWdata != Key1 && busWdata != Key2) |=> !strobes.unlocked); // R5

  AST_OPEN_PERSISTS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.unlocked && !(busWe && busAddr == KeyA)) |=> strobes.unlocked); // R6

endmodule

// File: rtl/key_guard_dp.sv
module key_guard_dp
  import key_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 1,
  parameter int unsigned STAT_ADDR = 2,
  parameter int unsigned MODE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  guard_strobe_t     strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              idleWake,
  output logic [DATA_W-1:0] busRdata,
  output logic              modeReq
);

  localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);

  logic [DATA_W-1:0] ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ctrlReg <= '0;
    else if (strobes.ctrlLoad) ctrlReg <= busWdata;
  end

  // Mode level follows the stored bit only at wake-up from idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modeReq <= 1'b0;
    else if (idleWake) modeReq <= ctrlReg[MODE_BIT];
  end

  // Key register and unmapped addresses read as zero
  always_comb begin
    busRdata = '0;
    if (busAddr == CtrlA)      busRdata = ctrlReg;
    else if (busAddr == StatA) busRdata = DATA_W'(strobes.unlocked);
  end

  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ctrlLoad |=> $stable(ctrlReg)); // R2

  AST_MODE_ONLY_ON_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    !idleWake |=> $stable(modeReq)); // R8

  AST_MODE_USES_OLD_BIT: assert property (@(posedge clk) disable iff (!rstN)
    idleWake |=> (modeReq == $past(ctrlReg[MODE_BIT]))); // R9

endmodule

// File: rtl/key_guard_top.sv
module key_guard_top
  import key_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned KEY_ADDR   = 0,
  parameter int unsigned CTRL_ADDR  = 1,
  parameter int unsigned STAT_ADDR  = 2,
  parameter int unsigned KEY_FIRST  = 'h87,
  parameter int unsigned KEY_SECOND = 'h59,
  parameter int unsigned MODE_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              idleWake,
  output logic              modeReq
);

  guard_strobe_t strobes;

  key_guard_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .strobes(strobes)
  );

  key_guard_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR), .MODE_BIT(MODE_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .idleWake(idleWake), .busRdata(busRdata), .modeReq(modeReq)
  );

endmodule

// File: tb/key_guard_top_tb_top.sv
module key_guard_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       idleWake = 1'b0;
  logic       modeReq;

  int checks = 0;
  int errors = 0;
  logic [7:0] rd;

  always #2.5 clk = ~clk;

  key_guard_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .idleWake(idleWake), .modeReq(modeReq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic wakePulse();
    @(negedge clk);
    idleWake = 1'b1;
    @(negedge clk);
    idleWake = 1'b0;
  endtask

  task automatic unlock();
    busWrite(4'd0, 8'h87);
    busWrite(4'd0, 8'h59);
  endtask

  task automatic t_reset_state();
    busRead(4'd1, rd); check("R1 ctrl", rd, 8'h00);
    busRead(4'd2, rd); check("R1 status", rd, 8'h00);
    check("R1 modeReq", {7'd0, modeReq}, 8'h00);
    busRead(4'd0, rd); check("R7 key read", rd, 8'h00);
  endtask

  task automatic t_locked_write();
    busWrite(4'd1, 8'hA5);
    busRead(4'd1, rd); check("R2 locked write", rd, 8'h00);
  endtask

  task automatic t_lone_second();
    busWrite(4'd0, 8'h59);
    busRead(4'd2, rd); check("R4 lone second", rd, 8'h00);
    busWrite(4'd1, 8'h3C);
    busRead(4'd1, rd); check("R4 ctrl still locked", rd, 8'h00);
  endtask

  task automatic t_broken_pair();
    busWrite(4'd0, 8'h87);
    busWrite(4'd0, 8'h12);
    busWrite(4'd0, 8'h59);
    busRead(4'd2, rd); check("R5 armed then bad key", rd, 8'h00);
  endtask

  task automatic t_restart_unlock();
    busWrite(4'd0, 8'h87);
    busWrite(4'd0, 8'h87);
    busRead(4'd2, rd); check("R4 not open after firsts", rd, 8'h00);
    busWrite(4'd0, 8'h59);
    busRead(4'd2, rd); check("R4 restart opens", rd, 8'h01);
    busWrite(4'd1, 8'hA5);
    busRead(4'd1, rd); check("R3 ctrl write lands", rd, 8'hA5);
    busWrite(4'd1, 8'h5A);
    busRead(4'd1, rd); check("R6 second ctrl write", rd, 8'h5A);
    busWrite(4'd0, 8'h59);
    busWrite(4'd0, 8'h87);
    busRead(4'd2, rd); check("R6 key values keep open", rd, 8'h01);
    busRead(4'd0, rd); check("R7 key read open", rd, 8'h00);
  endtask

  task automatic t_relock();
    busWrite(4'd0, 8'h00);
    busRead(4'd2, rd); check("R5 relock", rd, 8'h00);
    busWrite(4'd1, 8'hFF);
    busRead(4'd1, rd); check("R2 after relock", rd, 8'h5A);
  endtask

  task automatic t_mode();
    unlock();
    busWrite(4'd1, 8'h01);
    check("R8 no wake no change", {7'd0, modeReq}, 8'h00);
    wakePulse();
    check("R8 wake sets", {7'd0, modeReq}, 8'h01);
    busWrite(4'd1, 8'h00);
    check("R8 clear bit holds", {7'd0, modeReq}, 8'h01);
    wakePulse();
    check("R8 wake clears", {7'd0, modeReq}, 8'h00);
  endtask

  task automatic t_coincident();
    @(negedge clk);
    busAddr = 4'd1; busWdata = 8'h01; busWe = 1'b1; idleWake = 1'b1;
    @(negedge clk);
    busWe = 1'b0; idleWake = 1'b0;
    check("R9 wake uses old bit", {7'd0, modeReq}, 8'h00);
    busRead(4'd1, rd); check("R9 write landed", rd, 8'h01);
    wakePulse();
    check("R9 next wake sets", {7'd0, modeReq}, 8'h01);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset modeReq", {7'd0, modeReq}, 8'h00);
    busRead(4'd1, rd); check("R1 reset ctrl", rd, 8'h00);
    busRead(4'd2, rd); check("R1 reset status", rd, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset_state();
    t_locked_write();
    t_lone_second();
    t_broken_pair();
    t_restart_unlock();
    t_relock();
    t_mode();
    t_coincident();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule